// File: doc/BRIEF.md
# Interrupt Routing and Masking Controller

This block gathers thirty-two level-sensitive interrupt requests, arranged as two banks of sixteen. Each bank has an enable mask that software sets. Each source in a programmable subset has a 3-bit route field that steers it to one of five CPU interrupt lines. A line is raised when at least one source routed to it is both asserted and enabled.

Software reaches the block through a 16-bit register port. The port has two address windows, selected by `win_sel`, and byte offsets within each window. The block also offers a combinational lookup for interrupt dispatch. Software presents a line number on `query_sel`, and the lookup returns the first enabled source routed to that line. The scan covers bank 0 before bank 1, and the lowest source number first within a bank. If no source qualifies, the lookup reports no hit, and dispatch software treats that as a spurious interrupt.

Top module: `irq_router`

## Requirements
- R1: After reset, both masks read 0, `cpu_int` is 0 and route fields hold their defaults. Bank 0 source 2 is routed to line 1, bank 1 source 0 is routed to line 2, and every other source is routed to line 0.
- R2: The pending registers return the live source levels: window 0 offset 0x00 shows bank 0 and window 1 offset 0x00 shows bank 1. Writes to the pending registers have no effect.
- R3: The bank 0 mask is read/write at window 0 offset 0x0C and the bank 1 mask is read/write at window 1 offset 0x06. A 1 bit enables its source, and a write takes effect at the clock edge that samples the strobe.
- R4: All route registers are in window 0. Offset 0x04 holds bank 0 sources 0-4, offset 0x06 holds bank 0 sources 5-9, offset 0x1C holds bank 1 sources 0-4 and offset 0x1E holds bank 1 sources 5-9. Within a register, fields sit at bits 0, 3, 6, 9 and 12 in ascending source order, and bit 15 reads 0. Sources 10-15 of each bank are fixed to line 0.
- R5: A route field written with a value above 4 keeps its old value. The other fields in the same write still take their new values.
- R6: `cpu_int[n]` equals the OR of (level & enabled & route==n) over all sources, registered. It changes one clock after the input or register change that causes it.
- R7: The lookup scans bank 0 sources 0-15, then bank 1 sources 0-15. It returns the first source that is enabled and routed to `query_sel`, whether or not that source is pending. The result appears on `dec_valid`, `dec_bank` and `dec_src` in the same cycle as the query.
- R8: When no source matches, or `query_sel` is above 4, `dec_valid` is 0 and `dec_bank` and `dec_src` are 0.
- R9: Offsets that are not mapped read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_b0 | input | 16 | Bank 0 request levels |
| src_b1 | input | 16 | Bank 1 request levels |
| wr_en | input | 1 | Register write strobe |
| win_sel | input | 1 | Address window select (0 or 1) |
| reg_off | input | 5 | Byte offset within window |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, combinational |
| cpu_int | output | 5 | Registered CPU interrupt lines 0-4 |
| query_sel | input | 3 | Line number for the lookup |
| dec_valid | output | 1 | Lookup found a source |
| dec_bank | output | 1 | Bank of the found source |
| dec_src | output | 4 | Index of the found source |

## Verification
A wrong mask or route bit can be seen in two places. It appears at once on `rd_data` when its register is read, and on the lookup outputs in the same cycle as the query. It appears on `cpu_int` exactly one clock after a source routed through that bit is driven. A rejected field write that corrupted its neighbours would appear on the next read-back of that register. A lookup that broke the bank-0-first ordering would report the wrong bank as soon as sources in both banks qualify for the same line.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int SRC_N       = 16;
    localparam int OUT_N       = 5;
    localparam int FLD_W       = 3;
    localparam int FLD_PER_REG = 5;
    localparam int ASG_REGS    = 2;
    localparam int ASG_SRC     = FLD_PER_REG * ASG_REGS;
    localparam int OFF_W       = 5;
    localparam int DATA_W      = 16;

    localparam logic [OFF_W-1:0] OFF_PEND  = 5'h00;
    localparam logic [OFF_W-1:0] OFF_MASK0 = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_MASK1 = 5'h06;
    localparam logic [OFF_W-1:0] OFF_ASG0  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_ASG1  = 5'h1C;

    // byte offset of route register r of bank b (window 0)
    function automatic logic [OFF_W-1:0] asg_off(input int b, input int r);
        return (b == 0 ? OFF_ASG0 : OFF_ASG1) + OFF_W'(2 * r);
    endfunction

    // default line of source s in bank b
    function automatic int asg_default(input int b, input int s);
        if (b == 0 && s == 2) return 1;
        if (b == 1 && s == 0) return 2;
        return 0;
    endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NSRC = SRC_N,
    parameter int NOUT = OUT_N,
    parameter int FW   = FLD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         win_sel,
    input  logic [OFF_W-1:0]             reg_off,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [1:0][NSRC-1:0]         src,
    output logic [DATA_W-1:0]            rd_data,
    output logic [1:0][NSRC-1:0]         mask_q,
    output logic [1:0][NSRC-1:0][FW-1:0] asg_q
);
    localparam logic [FW-1:0] FLD_MAX = FW'(NOUT - 1);

    function automatic logic [1:0][NSRC-1:0][FW-1:0] build_rst();
        logic [1:0][NSRC-1:0][FW-1:0] m;
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < NSRC; s++)
                m[b][s] = FW'(asg_default(b, s));
        return m;
    endfunction
    localparam logic [1:0][NSRC-1:0][FW-1:0] ASG_RST = build_rst();

    logic                         wr_w0, wr_w1;
    logic [1:0][NSRC-1:0][FW-1:0] asg_nxt;

    assign wr_w0 = wr_en && !win_sel;
    assign wr_w1 = wr_en &&  win_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            if (wr_w0 && reg_off == OFF_MASK0) mask_q[0] <= wr_data[NSRC-1:0];
            if (wr_w1 && reg_off == OFF_MASK1) mask_q[1] <= wr_data[NSRC-1:0];
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            if (s < ASG_SRC) begin : g_prog
                localparam int RIDX  = s / FLD_PER_REG;
                localparam int SHIFT = (s % FLD_PER_REG) * FW;
                logic          hit;
                logic [FW-1:0] val;
                assign hit = wr_w0 && (reg_off == asg_off(b, RIDX));
                assign val = wr_data[SHIFT +: FW];
                assign asg_nxt[b][s] = (hit && val <= FLD_MAX) ? val : asg_q[b][s];
            end else begin : g_fixed
                assign asg_nxt[b][s] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) asg_q <= ASG_RST;
        else        asg_q <= asg_nxt;
    end

    always_comb begin
        rd_data = '0;
        if (!win_sel) begin
            if (reg_off == OFF_PEND)       rd_data = src[0];
            else if (reg_off == OFF_MASK0) rd_data = mask_q[0];
            for (int b = 0; b < 2; b++)
                for (int r = 0; r < ASG_REGS; r++)
                    if (reg_off == asg_off(b, r))
                        for (int k = 0; k < FLD_PER_REG; k++)
                            rd_data[k*FW +: FW] = asg_q[b][r*FLD_PER_REG + k];
        end else begin
            if (reg_off == OFF_PEND)       rd_data = src[1];
            else if (reg_off == OFF_MASK1) rd_data = mask_q[1];
        end
    end
endmodule

// File: rtl/irq_router_route.sv
module irq_router_route
    import irq_router_pkg::*;
#(
    parameter int NSRC = SRC_N,
    parameter int NOUT = OUT_N,
    parameter int FW   = FLD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0][NSRC-1:0]         src,
    input  logic [1:0][NSRC-1:0]         mask_q,
    input  logic [1:0][NSRC-1:0][FW-1:0] asg_q,
    output logic [NOUT-1:0]              cpu_int
);
    logic [NOUT-1:0] line_hit;

    always_comb begin
        line_hit = '0;
        for (int n = 0; n < NOUT; n++)
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < NSRC; s++)
                    if (src[b][s] && mask_q[b][s] && asg_q[b][s] == FW'(n))
                        line_hit[n] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_int <= '0;
        else        cpu_int <= line_hit;
    end
endmodule

// File: rtl/irq_router_cascade.sv
module irq_router_cascade
    import irq_router_pkg::*;
#(
    parameter int NSRC = SRC_N,
    parameter int FW   = FLD_W,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic [1:0][NSRC-1:0]         mask_q,
    input  logic [1:0][NSRC-1:0][FW-1:0] asg_q,
    input  logic [FW-1:0]                query_sel,
    output logic                         dec_valid,
    output logic                         dec_bank,
    output logic [SW-1:0]                dec_src
);
    always_comb begin
        dec_valid = 1'b0;
        dec_bank  = 1'b0;
        dec_src   = '0;
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < NSRC; s++)
                if (!dec_valid && mask_q[b][s] && asg_q[b][s] == query_sel) begin
                    dec_valid = 1'b1;
                    dec_bank  = 1'(b);
                    dec_src   = SW'(s);
                end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_b0,
    input  logic [SRC_N-1:0]  src_b1,
    input  logic              wr_en,
    input  logic              win_sel,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [OUT_N-1:0]  cpu_int,
    input  logic [FLD_W-1:0]  query_sel,
    output logic              dec_valid,
    output logic              dec_bank,
    output logic [$clog2(SRC_N)-1:0] dec_src
);
    logic [1:0][SRC_N-1:0]            src;
    logic [1:0][SRC_N-1:0]            mask_q;
    logic [1:0][SRC_N-1:0][FLD_W-1:0] asg_q;

    assign src = {src_b1, src_b0};

    irq_router_regs #(.NSRC(SRC_N), .NOUT(OUT_N), .FW(FLD_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .win_sel(win_sel),
        .reg_off(reg_off), .wr_data(wr_data), .src(src),
        .rd_data(rd_data), .mask_q(mask_q), .asg_q(asg_q)
    );

    irq_router_route #(.NSRC(SRC_N), .NOUT(OUT_N), .FW(FLD_W)) i_route (
        .clk(clk), .rst_n(rst_n), .src(src), .mask_q(mask_q),
        .asg_q(asg_q), .cpu_int(cpu_int)
    );

    irq_router_cascade #(.NSRC(SRC_N), .FW(FLD_W)) i_cascade (
        .mask_q(mask_q), .asg_q(asg_q), .query_sel(query_sel),
        .dec_valid(dec_valid), .dec_bank(dec_bank), .dec_src(dec_src)
    );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [1:0][SRC_N-1:0]            mask_q,
    input logic [1:0][SRC_N-1:0][FLD_W-1:0] asg_q,
    input logic [OUT_N-1:0]                 cpu_int,
    input logic [FLD_W-1:0]                 query_sel,
    input logic                             dec_valid,
    input logic                             dec_bank,
    input logic [$clog2(SRC_N)-1:0]         dec_src
);
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

    a_r5_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(asg_q));

    for (genvar b = 0; b < 2; b++) begin : g_b
        for (genvar s = 0; s < SRC_N; s++) begin : g_s
            a_r5_field_legal: assert property (@(posedge clk) disable iff (!rst_n)
                asg_q[b][s] <= FLD_W'(OUT_N - 1));
        end
    end

    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> (cpu_int == '0));

    a_r7_hit_ok: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (mask_q[dec_bank][dec_src] && asg_q[dec_bank][dec_src] == query_sel));

    a_r8_bad_query: assert property (@(posedge clk) disable iff (!rst_n)
        (query_sel > FLD_W'(OUT_N - 1)) |-> (!dec_valid && dec_bank == 1'b0 && dec_src == '0));
endmodule

bind irq_router irq_router_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mask_q(mask_q), .asg_q(asg_q),
    .cpu_int(cpu_int), .query_sel(query_sel), .dec_valid(dec_valid),
    .dec_bank(dec_bank), .dec_src(dec_src)
);

// File: tb/test_irq_router.sv
module test_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_b0 = '0, src_b1 = '0;
    logic        wr_en = 1'b0, win_sel = 1'b0;
    logic [4:0]  reg_off = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [4:0]  cpu_int;
    logic [2:0]  query_sel = '0;
    logic        dec_valid, dec_bank;
    logic [3:0]  dec_src;

    int n_cmp = 0, n_bad = 0;
    logic [15:0] m_mask [2];
    int          m_asg  [2][16];

    always #5 clk = ~clk;

    irq_router i_irq_router (
        .clk(clk), .rst_n(rst_n), .src_b0(src_b0), .src_b1(src_b1),
        .wr_en(wr_en), .win_sel(win_sel), .reg_off(reg_off), .wr_data(wr_data),
        .rd_data(rd_data), .cpu_int(cpu_int), .query_sel(query_sel),
        .dec_valid(dec_valid), .dec_bank(dec_bank), .dec_src(dec_src)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic w, input logic [4:0] o, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; win_sel = w; reg_off = o; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic w, input logic [4:0] o, input logic [15:0] exp);
        @(negedge clk);
        win_sel = w; reg_off = o;
        #1 chk(tag, {16'h0, rd_data}, {16'h0, exp});
    endtask

    function automatic logic [4:0] exp_int();
        logic [4:0] r = '0;
        for (int s = 0; s < 16; s++) begin
            if (src_b0[s] && m_mask[0][s]) r[m_asg[0][s]] = 1'b1;
            if (src_b1[s] && m_mask[1][s]) r[m_asg[1][s]] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [5:0] exp_dec(input int q);
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 16; s++)
                if (m_mask[b][s] && m_asg[b][s] == q)
                    return {1'b1, 1'(b), 4'(s)};
        return 6'h0;
    endfunction

    task automatic dec_chk(input string tag, input int q);
        @(negedge clk);
        query_sel = 3'(q);
        #1 chk(tag, {26'h0, dec_valid, dec_bank, dec_src}, {26'h0, exp_dec(q)});
    endtask

    task automatic t_reset();
        rd_chk("R1 mask0 reset", 1'b0, 5'h0C, 16'h0000);
        rd_chk("R1 mask1 reset", 1'b1, 5'h06, 16'h0000);
        rd_chk("R1 route b0 lo", 1'b0, 5'h04, 16'h0040);
        rd_chk("R1 route b0 hi", 1'b0, 5'h06, 16'h0000);
        rd_chk("R1 route b1 lo", 1'b0, 5'h1C, 16'h0002);
        rd_chk("R1 route b1 hi", 1'b0, 5'h1E, 16'h0000);
        chk("R1 cpu_int reset", {27'h0, cpu_int}, 32'h0);
        dec_chk("R1 lookup no mask", 0);
    endtask

    task automatic t_pending();
        @(negedge clk);
        src_b0 = 16'hA5A5; src_b1 = 16'h1234;
        rd_chk("R2 pend b0", 1'b0, 5'h00, 16'hA5A5);
        rd_chk("R2 pend b1", 1'b1, 5'h00, 16'h1234);
        wr(1'b0, 5'h00, 16'hFFFF);
        wr(1'b1, 5'h00, 16'hFFFF);
        rd_chk("R2 pend b0 write ignored", 1'b0, 5'h00, 16'hA5A5);
        rd_chk("R2 mask0 untouched", 1'b0, 5'h0C, 16'h0000);
        rd_chk("R2 mask1 untouched", 1'b1, 5'h06, 16'h0000);
        @(negedge clk);
        chk("R2 no line raised", {27'h0, cpu_int}, 32'h0);
    endtask

    task automatic t_mask();
        wr(1'b0, 5'h0C, 16'h00FF); m_mask[0] = 16'h00FF;
        rd_chk("R3 mask0 rw", 1'b0, 5'h0C, 16'h00FF);
        wr(1'b1, 5'h06, 16'h8001); m_mask[1] = 16'h8001;
        rd_chk("R3 mask1 rw", 1'b1, 5'h06, 16'h8001);
        @(negedge clk);
        chk("R3 enabled lines", {27'h0, cpu_int}, {27'h0, exp_int()});
    endtask

    task automatic t_unmapped();
        wr(1'b1, 5'h0C, 16'hFFFF);
        rd_chk("R9 w1 0x0C reads 0", 1'b1, 5'h0C, 16'h0000);
        rd_chk("R9 mask0 unchanged", 1'b0, 5'h0C, 16'h00FF);
        wr(1'b0, 5'h02, 16'hFFFF);
        rd_chk("R9 w0 0x02 reads 0", 1'b0, 5'h02, 16'h0000);
        rd_chk("R9 w1 route offset reads 0", 1'b1, 5'h04, 16'h0000);
        rd_chk("R9 route b0 lo unchanged", 1'b0, 5'h04, 16'h0040);
    endtask

    task automatic t_route_fields();
        wr(1'b0, 5'h06, 16'h829C);
        m_asg[0][5] = 4; m_asg[0][6] = 3; m_asg[0][7] = 2; m_asg[0][8] = 1; m_asg[0][9] = 0;
        rd_chk("R4 route b0 hi layout", 1'b0, 5'h06, 16'h029C);
        wr(1'b0, 5'h04, 16'h2ACF);
        m_asg[0][1] = 1; m_asg[0][2] = 3; m_asg[0][4] = 2;
        rd_chk("R5 illegal fields kept", 1'b0, 5'h04, 16'h20C8);
        wr(1'b0, 5'h1E, 16'h0004);
        m_asg[1][5] = 4;
        rd_chk("R4 route b1 hi", 1'b0, 5'h1E, 16'h0004);
        rd_chk("R4 route b1 lo kept", 1'b0, 5'h1C, 16'h0002);
    endtask

    task automatic t_lines();
        @(negedge clk);
        chk("R6 lines after routing", {27'h0, cpu_int}, {27'h0, exp_int()});
        begin
            logic [4:0] prev;
            prev = cpu_int;
            src_b0 = 16'h0000; src_b1 = 16'h8001;
            #1 chk("R6 one-clock latency", {27'h0, cpu_int}, {27'h0, prev});
        end
        @(negedge clk);
        chk("R6 bank1 lines", {27'h0, cpu_int}, 32'h05);
        src_b1 = 16'h0020;
        @(negedge clk);
        chk("R6 disabled source quiet", {27'h0, cpu_int}, 32'h00);
        src_b0 = 16'h0080; src_b1 = 16'h0000;
        @(negedge clk);
        chk("R6 src7 to line2", {27'h0, cpu_int}, {27'h0, exp_int()});
    endtask

    task automatic t_lookup();
        for (int q = 0; q < 8; q++) dec_chk($sformatf("R7 lookup q%0d", q), q);
        dec_chk("R8 query 5 no hit", 5);
        dec_chk("R8 query 7 no hit", 7);
        wr(1'b0, 5'h0C, 16'h0000); m_mask[0] = 16'h0000;
        dec_chk("R7 bank1 src0 on line2", 2);
        dec_chk("R7 bank1 src15 on line0", 0);
        dec_chk("R8 line1 empty", 1);
        wr(1'b1, 5'h06, 16'h0000); m_mask[1] = 16'h0000;
        src_b0 = 16'hFFFF; src_b1 = 16'hFFFF;
        dec_chk("R8 all masked", 0);
        @(negedge clk);
        chk("R6 all masked lines", {27'h0, cpu_int}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            m_mask[b] = '0;
            for (int s = 0; s < 16; s++) m_asg[b][s] = 0;
        end
        m_asg[0][2] = 1;
        m_asg[1][0] = 2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pending();
        t_mask();
        t_unmapped();
        t_route_fields();
        t_lines();
        t_lookup();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule